// File: doc/BRIEF.md
# Extended-Precision Condition Code Generator

This block turns an 80-bit extended-precision value, or the ordering of two such values, into a four-bit condition code (C3, C2, C1, C0). An operation select chooses what happens. Examine classifies a single operand. Compare orders operand A against operand B. Test orders operand A against positive zero. Reduce takes the three low quotient bits and a completion flag from an external partial-remainder step and packs them into the code. A second path exposes the code as three processor-style flags: zero, parity and carry.

Each operand has sign in bit 79, a 15-bit biased exponent in bits 78:64, an explicit integer bit in bit 63 and a 63-bit fraction in bits 62:0. A per-operand empty input marks a register slot that holds no value. The caller raises `start` for one cycle with the operation inputs valid. The code register and `ccValid` update on that clock edge, so both can be read during the following cycle. The code holds its value while `start` is low.

Top module: `ccode_gen`

## Requirements
- R1: After reset, `cc` is 4'b0000, `ccValid` is 0 and all three flags are 0.
- R2: `cc` takes its new value, and `ccValid` is 1, in the cycle after a cycle with `start` high. `ccValid` is 0 after a cycle with `start` low, and `cc` then keeps its value.
- R3: Examine (`opSel`=2'b00) writes {C3,C2,C1,C0} as follows, with s taken from bit 79:
  - unnormal 0,0,s,0
  - NaN 0,0,s,1
  - normal 0,1,s,0
  - infinity 0,1,s,1
  - zero 1,0,s,0
  - denormal 1,1,s,0
  
  The class follows from the exponent field.
  - All-ones exponent: infinity only when the integer bit is 1 and the fraction is zero. Every other value is NaN.
  - Zero exponent: zero when the mantissa is zero, denormal otherwise.
  - Any other exponent: unnormal when the integer bit is 0, normal otherwise.
- R4: Examine with `emptyA` high writes 4'b1001, whatever `opA` holds.
- R5: Compare (`opSel`=2'b01) writes {C3,C2,C0} as 000 for A>B, 001 for A<B and 100 for A=B. Values are ordered numerically, so denormals and infinities compare by value, and +0 equals -0.
- R6: Compare gives {C3,C2,C0}=111 (unordered) when either operand is empty, a NaN or an unnormal.
- R7: Test (`opSel`=2'b10) gives the compare encodings of A against +0. `opB` and `emptyB` have no effect in this mode.
- R8: Compare and test leave C1 at its previous value.
- R9: Reduce (`opSel`=2'b11) with `reduceDone`=1 writes C1=`quotBits[0]`, C3=`quotBits[1]`, C0=`quotBits[2]` and C2=0.
- R10: Reduce with `reduceDone`=0 sets C2 to 1 and leaves C3, C1 and C0 unchanged.
- R11: `zeroFlag` equals C3, `parityFlag` equals C2 and `carryFlag` equals C0, at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches one operation |
| opSel | input | 2 | 00 examine, 01 compare, 10 test, 11 reduce |
| opA | input | 80 | First operand |
| opB | input | 80 | Second operand (compare only) |
| emptyA | input | 1 | Operand A slot is empty |
| emptyB | input | 1 | Operand B slot is empty |
| quotBits | input | 3 | Low quotient bits of a reduction |
| reduceDone | input | 1 | Reduction completed |
| cc | output | 4 | Condition code {C3,C2,C1,C0} |
| ccValid | output | 1 | Code was written on the last edge |
| zeroFlag | output | 1 | Zero flag view of C3 |
| parityFlag | output | 1 | Parity flag view of C2 |
| carryFlag | output | 1 | Carry flag view of C0 |

## Verification
The bench runs every value of a fixed set through examine, test and all-pairs compare, with every combination of the two empty flags. The set covers both zeros, small and large denormals, normals, infinities, a NaN, an all-ones exponent with an empty mantissa, and unnormals.

The sweep exposes the following faults:
- A design that compared signed zeros bitwise would report -0 as less than +0.
- Ordering that ignored the sign on negative magnitudes would reverse every negative pair.
- Treating an unnormal or an empty slot as ordered would produce a false greater or less.
- A C1 overwritten by compare or test shows up as a wrong C1 after the following examine.

Every quotient pattern goes through reduce, both complete and incomplete, which catches swapped quotient bit positions. Cycles without `start` follow with the inputs changed, to catch a code that does not hold.

// File: rtl/ccode_pkg.sv
package ccode_pkg;
  typedef enum logic [1:0] {
    OP_EXAM = 2'b00,
    OP_CMP  = 2'b01,
    OP_TST  = 2'b10,
    OP_RED  = 2'b11
  } opSel_e;

  typedef enum logic [2:0] {
    CL_UNNORM,
    CL_NAN,
    CL_NORMAL,
    CL_INF,
    CL_ZERO,
    CL_DENORM
  } valClass_e;

  typedef struct packed {
    logic loadExam;
    logic loadOrd;
    logic zeroRef;
    logic loadRed;
  } ccStrobe_t;
endpackage

// File: rtl/ccode_classify.sv
module ccode_classify
  import ccode_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int MANT_W = 64,
  localparam int VAL_W = 1 + EXP_W + MANT_W
) (
  input  logic [VAL_W-1:0] val,
  output valClass_e        cls,
  output logic             sgn
);
  logic [EXP_W-1:0] expField;
  logic             intBit;
  logic             fracZero;

  assign expField = val[VAL_W-2 -: EXP_W];
  assign intBit   = val[MANT_W-1];
  assign fracZero = ~|val[MANT_W-2:0];
  assign sgn      = val[VAL_W-1];

  always_comb begin
    if (&expField)
      cls = (intBit && fracZero) ? CL_INF : CL_NAN;
    else if (~|expField)
      cls = (!intBit && fracZero) ? CL_ZERO : CL_DENORM;
    else if (!intBit)
      cls = CL_UNNORM;
    else
      cls = CL_NORMAL;
  end
endmodule

// File: rtl/ccode_ctrl.sv
module ccode_ctrl
  import ccode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] opSel,
  output ccStrobe_t  strobe,
  output logic       ccValid
);
  always_comb begin
    strobe = '0;
    if (start) begin
      unique case (opSel_e'(opSel))
        OP_EXAM: strobe.loadExam = 1'b1;
        OP_CMP:  strobe.loadOrd  = 1'b1;
        OP_TST:  begin strobe.loadOrd = 1'b1; strobe.zeroRef = 1'b1; end
        OP_RED:  strobe.loadRed  = 1'b1;
        default: strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ccValid <= 1'b0;
    else        ccValid <= start;
  end
endmodule

// File: rtl/ccode_dpath.sv
module ccode_dpath
  import ccode_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int MANT_W = 64,
  localparam int VAL_W = 1 + EXP_W + MANT_W,
  localparam int MAG_W = VAL_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ccStrobe_t        strobe,
  input  logic [VAL_W-1:0] opA,
  input  logic [VAL_W-1:0] opB,
  input  logic             emptyA,
  input  logic             emptyB,
  input  logic [2:0]       quotBits,
  input  logic             reduceDone,
  output logic [3:0]       cc
);
  logic [VAL_W-1:0] opnd  [2];
  logic             empty [2];
  valClass_e        cls   [2];
  logic             sgn   [2];
  logic             effNeg[2];

  assign opnd[0]  = opA;
  assign opnd[1]  = strobe.zeroRef ? '0 : opB;
  assign empty[0] = emptyA;
  assign empty[1] = strobe.zeroRef ? 1'b0 : emptyB;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    ccode_classify #(.EXP_W(EXP_W), .MANT_W(MANT_W)) i_cls (
      .val(opnd[g]),
      .cls(cls[g]),
      .sgn(sgn[g])
    );
    assign effNeg[g] = sgn[g] && (cls[g] != CL_ZERO);
  end

  logic       unordered;
  logic [2:0] ordCode;
  logic [2:0] examCode;
  logic [3:0] ccNext;

  assign unordered = empty[0] || empty[1] ||
                     cls[0] == CL_NAN || cls[1] == CL_NAN ||
                     cls[0] == CL_UNNORM || cls[1] == CL_UNNORM;

  // ordCode is {C3,C2,C0}
  always_comb begin
    logic [MAG_W-1:0] magA, magB;
    magA = opnd[0][MAG_W-1:0];
    magB = opnd[1][MAG_W-1:0];
    if (unordered)
      ordCode = 3'b111;
    else if (cls[0] == CL_ZERO && cls[1] == CL_ZERO)
      ordCode = 3'b100;
    else if (effNeg[0] != effNeg[1])
      ordCode = effNeg[0] ? 3'b001 : 3'b000;
    else if (magA == magB)
      ordCode = 3'b100;
    else
      ordCode = ((magA > magB) ^ effNeg[0]) ? 3'b000 : 3'b001;
  end

  // examCode is {C3,C2,C0}
  always_comb begin
    unique case (cls[0])
      CL_UNNORM: examCode = 3'b000;
      CL_NAN:    examCode = 3'b001;
      CL_NORMAL: examCode = 3'b010;
      CL_INF:    examCode = 3'b011;
      CL_ZERO:   examCode = 3'b100;
      CL_DENORM: examCode = 3'b110;
      default:   examCode = 3'b001;
    endcase
  end

  always_comb begin
    ccNext = cc;
    if (strobe.loadExam)
      ccNext = empty[0] ? 4'b1001 : {examCode[2:1], sgn[0], examCode[0]};
    else if (strobe.loadOrd)
      ccNext = {ordCode[2:1], cc[1], ordCode[0]};
    else if (strobe.loadRed)
      ccNext = reduceDone ? {quotBits[1], 1'b0, quotBits[0], quotBits[2]}
                          : {cc[3], 1'b1, cc[1], cc[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc <= 4'b0000;
    else        cc <= ccNext;
  end
endmodule

// File: rtl/ccode_gen.sv
module ccode_gen
  import ccode_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int MANT_W = 64,
  localparam int VAL_W = 1 + EXP_W + MANT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       opSel,
  input  logic [VAL_W-1:0] opA,
  input  logic [VAL_W-1:0] opB,
  input  logic             emptyA,
  input  logic             emptyB,
  input  logic [2:0]       quotBits,
  input  logic             reduceDone,
  output logic [3:0]       cc,
  output logic             ccValid,
  output logic             zeroFlag,
  output logic             parityFlag,
  output logic             carryFlag
);
  ccStrobe_t strobe;

  ccode_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .opSel(opSel),
    .strobe(strobe), .ccValid(ccValid)
  );

  ccode_dpath #(.EXP_W(EXP_W), .MANT_W(MANT_W)) i_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opA(opA), .opB(opB),
    .emptyA(emptyA), .emptyB(emptyB), .quotBits(quotBits),
    .reduceDone(reduceDone), .cc(cc)
  );

  assign zeroFlag   = cc[3];
  assign parityFlag = cc[2];
  assign carryFlag  = cc[0];
endmodule

// File: rtl/ccode_chk.sv
module ccode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] opSel,
  input logic       emptyA,
  input logic       emptyB,
  input logic [2:0] quotBits,
  input logic       reduceDone,
  input logic [3:0] cc,
  input logic       ccValid
);
  p_valid_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ccValid);

  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!ccValid && $stable(cc)));

  p_empty_exam_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opSel == 2'b00 && emptyA) |=> cc == 4'b1001);

  p_empty_unordered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opSel == 2'b01 && (emptyA || emptyB)) |=> (cc[3] && cc[2] && cc[0]));

  p_c1_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (opSel == 2'b01 || opSel == 2'b10)) |=> $stable(cc[1]));

  p_reduce_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opSel == 2'b11 && reduceDone) |=>
      (!cc[2] && cc[1] == $past(quotBits[0]) && cc[3] == $past(quotBits[1])
       && cc[0] == $past(quotBits[2])));

  p_reduce_partial_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opSel == 2'b11 && !reduceDone) |=>
      (cc[2] && $stable(cc[3]) && $stable(cc[1]) && $stable(cc[0])));
endmodule

bind ccode_gen ccode_chk i_chk (.*);

// File: tb/test_ccode_gen.sv
module test_ccode_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [79:0] opA = '0, opB = '0;
  logic        emptyA = 1'b0, emptyB = 1'b0;
  logic [2:0]  quotBits = 3'b000;
  logic        reduceDone = 1'b0;
  logic [3:0]  cc;
  logic        ccValid, zeroFlag, parityFlag, carryFlag;

  int checks = 0;
  int errors = 0;
  logic [3:0] expCc = 4'b0000;
  logic [79:0] vals [14];

  always #4 clk = ~clk;

  ccode_gen i_ccode_gen (.*);

  function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  function automatic logic isBad(input logic [79:0] v);
    logic [14:0] e = v[78:64];
    if (e == 15'h7fff) return v[63:0] != 64'h8000_0000_0000_0000;
    if (e != 0 && v[63] == 1'b0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic signed [81:0] toNum(input logic [79:0] v);
    logic signed [81:0] m = $signed({3'b000, v[78:0]});
    return v[79] ? -m : m;
  endfunction

  function automatic logic [2:0] refOrd(input logic [79:0] a, input logic ea,
                                        input logic [79:0] b, input logic eb);
    if (ea || eb || isBad(a) || isBad(b)) return 3'b111;
    if (toNum(a) == toNum(b)) return 3'b100;
    return (toNum(a) > toNum(b)) ? 3'b000 : 3'b001;
  endfunction

  function automatic logic [3:0] refExam(input logic [79:0] v, input logic ea);
    logic [14:0] e = v[78:64];
    logic s = v[79];
    if (ea) return 4'b1001;
    if (e == 15'h7fff)
      return (v[63:0] == 64'h8000_0000_0000_0000) ? {2'b01, s, 1'b1} : {2'b00, s, 1'b1};
    if (e == 0)
      return (v[63:0] == 0) ? {2'b10, s, 1'b0} : {2'b11, s, 1'b0};
    return v[63] ? {2'b01, s, 1'b0} : {2'b00, s, 1'b0};
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic runOp(input string req, input logic [1:0] sel, input logic [79:0] a,
                       input logic [79:0] b, input logic ea, input logic eb,
                       input logic [2:0] q, input logic done);
    @(negedge clk);
    opSel = sel; opA = a; opB = b; emptyA = ea; emptyB = eb;
    quotBits = q; reduceDone = done; start = 1'b1;
    case (sel)
      2'b00: expCc = refExam(a, ea);
      2'b01: begin logic [2:0] o = refOrd(a, ea, b, eb); expCc = {o[2:1], expCc[1], o[0]}; end
      2'b10: begin logic [2:0] o = refOrd(a, ea, 80'd0, 1'b0); expCc = {o[2:1], expCc[1], o[0]}; end
      default: expCc = done ? {q[1], 1'b0, q[0], q[2]} : {expCc[3], 1'b1, expCc[1], expCc[0]};
    endcase
    @(negedge clk);
    start = 1'b0;
    check(req, cc, expCc);
    check("R2 valid", {3'b0, ccValid}, 4'b0001);
    check("R11 flags", {zeroFlag, parityFlag, 1'b0, carryFlag}, {expCc[3], expCc[2], 1'b0, expCc[0]});
  endtask

  initial begin
    vals[0]  = mk(0, 15'h0000, 64'h0);
    vals[1]  = mk(1, 15'h0000, 64'h0);
    vals[2]  = mk(0, 15'h0000, 64'h1);
    vals[3]  = mk(1, 15'h0000, 64'h7fff_ffff_ffff_ffff);
    vals[4]  = mk(0, 15'h0001, 64'h8000_0000_0000_0000);
    vals[5]  = mk(0, 15'h3fff, 64'hc000_0000_0000_0000);
    vals[6]  = mk(1, 15'h3fff, 64'hc000_0000_0000_0000);
    vals[7]  = mk(1, 15'h3fff, 64'h8000_0000_0000_0000);
    vals[8]  = mk(0, 15'h7ffe, 64'hffff_ffff_ffff_ffff);
    vals[9]  = mk(0, 15'h7fff, 64'h8000_0000_0000_0000);
    vals[10] = mk(1, 15'h7fff, 64'h8000_0000_0000_0000);
    vals[11] = mk(1, 15'h7fff, 64'hc000_0000_0000_0001);
    vals[12] = mk(0, 15'h7fff, 64'h0);
    vals[13] = mk(1, 15'h0005, 64'h4000_0000_0000_0000);

    repeat (3) @(negedge clk);
    check("R1 reset cc", cc, 4'b0000);
    check("R1 reset valid/flags", {ccValid, zeroFlag, parityFlag, carryFlag}, 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < 14; i++) begin
      runOp("R3 examine", 2'b00, vals[i], '0, 1'b0, 1'b0, 3'b0, 1'b0);
      runOp("R4 examine empty", 2'b00, vals[i], '0, 1'b1, 1'b0, 3'b0, 1'b0);
    end

    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 14; i++) begin
        runOp("R3 set C1", 2'b00, vals[(i + 3) % 14], '0, 1'b0, 1'b0, 3'b0, 1'b0);
        runOp("R7 test vs zero (R8 C1)", 2'b10, vals[i], vals[(i + 5) % 14],
              1'b0, k[0], 3'b0, 1'b0);
      end

    for (int i = 0; i < 14; i++)
      for (int j = 0; j < 14; j++)
        for (int e = 0; e < 4; e++) begin
          if (e == 0) runOp("R3 set C1", 2'b00, vals[j], '0, 1'b0, 1'b0, 3'b0, 1'b0);
          runOp((e == 0) ? "R5 compare (R8 C1)" : "R6 unordered on empty", 2'b01,
                vals[i], vals[j], e[0], e[1], 3'b0, 1'b0);
        end

    for (int q = 0; q < 8; q++) begin
      runOp("R9 reduce complete", 2'b11, '0, '0, 1'b0, 1'b0, q[2:0], 1'b1);
      runOp("R10 reduce partial", 2'b11, '0, '0, 1'b0, 1'b0, ~q[2:0], 1'b0);
    end

    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      opSel = i[1:0]; opA = vals[i + 2]; emptyA = i[0]; quotBits = 3'b101; reduceDone = 1'b1;
      @(negedge clk);
      check("R2 hold without start", cc, expCc);
      check("R2 valid low", {3'b0, ccValid}, 4'b0000);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule